// File: doc/BRIEF.md
# Deflection Device Power-Up Sequencer

This block sits on the host side of a two-wire control bus and walks a deflection device from standby into full operation. Every access it makes is one complete single-register write (device address, subaddress, data) handed to a byte-level bus master through a command channel. It then waits for that master to report whether the device acknowledged. A start pulse begins the walk. The block first clears the standby bit in the control register at subaddress 1AH, retrying while the device stays silent in its power-on reset. It then loads each entry of a small register table. It waits a parameterised number of millisecond ticks so that the horizontal drive can settle. Last, it writes the soft-start value.

Once running, the block holds `done_o` high. A shutdown pulse writes the control register back to 00H, which starts the device's soft-down ramp, and the block then returns to idle. A refused write in the table, the soft-start or the shutdown phase ends the sequence in an error state. Only a new start pulse leaves that state.

The command channel is valid/ready. `cmd_valid_o` stays high with address, subaddress and data unchanged until the cycle in which `cmd_ready_i` is high. After that handshake no further command is offered until one response cycle (`rsp_valid_i` high) has been seen. `rsp_valid_i` is ignored while no command is in flight, and `cmd_ready_i` is ignored while `cmd_valid_o` is low.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o` and `cmd_valid_o` are all low.
- R2: A start pulse in idle makes `busy_o` high, and the first command offered is address 8CH, subaddress 1AH, data 00H.
- R3: While `cmd_valid_o` is high and `cmd_ready_i` is low, valid stays high and the address, subaddress and data do not change. After a handshake, no new command is offered before a response is received.
- R4: When the first write is refused (`rsp_nack_i` high with `rsp_valid_i`), that write is offered again only after RETRY_MS further `ms_tick_i` pulses. No command is offered in between.
- R5: If MAX_TRIES consecutive attempts of the first write are refused, `error_o` goes high, `busy_o` goes low, and no further command is offered.
- R6: After the first write is acknowledged, table entry i is written for i = 0 up to NUM_REGS-1 in increasing order, each as its own command. Entry i takes its subaddress from `tbl_sub_i[8*i+7:8*i]` and its data from `tbl_dat_i[8*i+7:8*i]`.
- R7: A refused table write ends the sequence at once, with `error_o` high, `busy_o` low, no retry and no further command.
- R8: The soft-start write is offered only after SETTLE_MS `ms_tick_i` pulses have followed the response to the last table write. A SETTLE_MS below 80 is raised to 80.
- R9: The soft-start write is subaddress 1AH, data 02H. Once it is acknowledged, `done_o` is high and `busy_o` low. At most one of `busy_o`, `done_o` and `error_o` is high at any time.
- R10: A shutdown pulse while `done_o` is high offers subaddress 1AH, data 00H. Once it is acknowledged, all three status outputs are low (idle).
- R11: A start pulse is ignored while `busy_o` or `done_o` is high. A start pulse while `error_o` is high restarts the sequence from the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| shutdown_i | input | 1 | Shutdown pulse, used while running |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| tbl_sub_i | input | 8*NUM_REGS | Table subaddresses, entry i in bits 8i+7..8i |
| tbl_dat_i | input | 8*NUM_REGS | Table data, entry i in bits 8i+7..8i |
| cmd_valid_o | output | 1 | A write command is offered |
| cmd_ready_i | input | 1 | Bus master accepts the offered command |
| cmd_addr_o | output | 8 | Device address |
| cmd_sub_o | output | 8 | Register subaddress |
| cmd_data_o | output | 8 | Register data |
| rsp_valid_i | input | 1 | Transfer-complete strobe |
| rsp_nack_i | input | 1 | With `rsp_valid_i`: the device did not acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Device in full operation |
| error_o | output | 1 | Sequence aborted |

## Verification
The hardest state to reach is the retry budget running out. It takes MAX_TRIES refusals in a row, each followed by a full RETRY_MS tick wait, and only then does the block give up. The bench models the bus master in a task that can refuse a command, and it repeats that refusal until the limit. At each retry it counts the tick pulses between the refusal and the next offer. A second case needs the sequence to break partway through the table: the bench acknowledges the wake write after several refusals, then refuses a mid-table entry. It then checks that the block stays quiet.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  localparam logic [7:0] CTRL_SUB     = 8'h1A;
  localparam logic [7:0] CTRL_WAKE    = 8'h00;
  localparam logic [7:0] CTRL_SOFT_ON = 8'h02;
  localparam logic [7:0] CTRL_RAMPDN  = 8'h00;
  localparam int unsigned SETTLE_FLOOR = 80;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE, ST_RETRY, ST_TABLE, ST_SETTLE,
    ST_SOFT, ST_RUN, ST_SHUT, ST_ERR
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_WAIT} port_ph_e;

  typedef struct packed {
    logic [7:0] sub;
    logic [7:0] data;
  } wr_req_t;
endpackage

// File: rtl/pwrup_wr_port.sv
module pwrup_wr_port
  import pwrup_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h8C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  wr_req_t    req_wr_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [7:0] cmd_addr_o,
  output logic [7:0] cmd_sub_o,
  output logic [7:0] cmd_data_o,
  input  logic       rsp_valid_i,
  input  logic       rsp_nack_i,
  output logic       fin_o,
  output logic       fin_nack_o
);
  port_ph_e ph_q;
  wr_req_t  hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      hold_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          hold_q <= req_wr_i;
          ph_q   <= PH_SEND;
        end
        PH_SEND: if (cmd_ready_i) ph_q <= PH_WAIT;
        PH_WAIT: if (rsp_valid_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (ph_q == PH_SEND);
  assign cmd_addr_o  = DEV_ADDR;
  assign cmd_sub_o   = hold_q.sub;
  assign cmd_data_o  = hold_q.data;
  assign fin_o       = (ph_q == PH_WAIT) && rsp_valid_i;
  assign fin_nack_o  = fin_o && rsp_nack_i;

  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_sub_o) && $stable(cmd_data_o)));

  assert_req_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> (ph_q == PH_IDLE));
endmodule

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (tick_i && (cnt_q != lim_q)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == lim_q);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  assert_expire_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> $past(tick_i));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR  = 8'h8C,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned SETTLE_MS = 80,
  parameter int unsigned RETRY_MS  = 10,
  parameter int unsigned MAX_TRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  shutdown_i,
  input  logic                  ms_tick_i,
  input  logic [8*NUM_REGS-1:0] tbl_sub_i,
  input  logic [8*NUM_REGS-1:0] tbl_dat_i,
  output logic                  cmd_valid_o,
  input  logic                  cmd_ready_i,
  output logic [7:0]            cmd_addr_o,
  output logic [7:0]            cmd_sub_o,
  output logic [7:0]            cmd_data_o,
  input  logic                  rsp_valid_i,
  input  logic                  rsp_nack_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  error_o
);
  localparam int unsigned SETTLE_EFF = (SETTLE_MS < SETTLE_FLOOR) ? SETTLE_FLOOR : SETTLE_MS;
  localparam int unsigned RETRY_EFF  = (RETRY_MS < 1) ? 1 : RETRY_MS;
  localparam int unsigned TMR_MAX    = (SETTLE_EFF > RETRY_EFF) ? SETTLE_EFF : RETRY_EFF;
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
  localparam int unsigned IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned TRY_W      = $clog2(MAX_TRIES + 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TRY_W-1:0] tries_q;
  logic             issued_q;

  logic             req;
  wr_req_t          req_wr;
  logic             fin, fin_nack;
  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_limit;
  logic             cmd_state;

  wr_req_t tbl_entry [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_tbl
    assign tbl_entry[g].sub  = tbl_sub_i[8*g +: 8];
    assign tbl_entry[g].data = tbl_dat_i[8*g +: 8];
  end

  assign cmd_state = (state_q == ST_WAKE) || (state_q == ST_TABLE) ||
                     (state_q == ST_SOFT) || (state_q == ST_SHUT);
  assign req = cmd_state && !issued_q;

  always_comb begin
    req_wr = '{sub: CTRL_SUB, data: CTRL_WAKE};
    unique case (state_q)
      ST_TABLE: req_wr = tbl_entry[idx_q];
      ST_SOFT:  req_wr = '{sub: CTRL_SUB, data: CTRL_SOFT_ON};
      ST_SHUT:  req_wr = '{sub: CTRL_SUB, data: CTRL_RAMPDN};
      default:  req_wr = '{sub: CTRL_SUB, data: CTRL_WAKE};
    endcase
  end

  always_comb begin
    tmr_load  = 1'b0;
    tmr_limit = TMR_W'(RETRY_EFF);
    if (fin && fin_nack && state_q == ST_WAKE) begin
      tmr_load  = 1'b1;
      tmr_limit = TMR_W'(RETRY_EFF);
    end else if (fin && !fin_nack && state_q == ST_TABLE &&
                 idx_q == IDX_W'(NUM_REGS - 1)) begin
      tmr_load  = 1'b1;
      tmr_limit = TMR_W'(SETTLE_EFF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      tries_q  <= '0;
      issued_q <= 1'b0;
    end else begin
      if (req) issued_q <= 1'b1;
      else if (fin) issued_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_ERR: if (start_i) begin
          state_q <= ST_WAKE;
          tries_q <= '0;
        end
        ST_WAKE: if (fin) begin
          if (!fin_nack) begin
            state_q <= ST_TABLE;
            idx_q   <= '0;
          end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
            state_q <= ST_ERR;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_RETRY;
          end
        end
        ST_RETRY: if (tmr_expired) state_q <= ST_WAKE;
        ST_TABLE: if (fin) begin
          if (fin_nack) state_q <= ST_ERR;
          else if (idx_q == IDX_W'(NUM_REGS - 1)) state_q <= ST_SETTLE;
          else idx_q <= idx_q + 1'b1;
        end
        ST_SETTLE: if (tmr_expired) state_q <= ST_SOFT;
        ST_SOFT: if (fin) state_q <= fin_nack ? ST_ERR : ST_RUN;
        ST_RUN: if (shutdown_i) state_q <= ST_SHUT;
        ST_SHUT: if (fin) state_q <= fin_nack ? ST_ERR : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = cmd_state || (state_q == ST_RETRY) || (state_q == ST_SETTLE);
  assign done_o  = (state_q == ST_RUN);
  assign error_o = (state_q == ST_ERR);

  pwrup_wr_port #(.DEV_ADDR(DEV_ADDR)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .req_wr_i   (req_wr),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o (cmd_addr_o),
    .cmd_sub_o  (cmd_sub_o),
    .cmd_data_o (cmd_data_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_nack_i (rsp_nack_i),
    .fin_o      (fin),
    .fin_nack_o (fin_nack)
  );

  pwrup_tick_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .limit_i  (tmr_limit),
    .tick_i   (ms_tick_i),
    .expired_o(tmr_expired)
  );

  // Independent tick count over the settle window, used only by assertions.
  logic [TMR_W-1:0] chk_ticks_q;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_ticks_q <= '0;
    else if (state_q == ST_SETTLE) begin
      if (ms_tick_i && chk_ticks_q != TMR_W'(SETTLE_EFF)) chk_ticks_q <= chk_ticks_q + 1'b1;
    end else if (state_q != ST_SOFT) chk_ticks_q <= '0;
  end

  assert_settle_elapsed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && state_q == ST_SOFT) |-> (chk_ticks_q == TMR_W'(SETTLE_EFF)));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy_o, done_o, error_o}) <= 1);

  assert_error_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> $past(rsp_valid_i && rsp_nack_i));

  assert_tries_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < TRY_W'(MAX_TRIES));

  assert_quiet_in_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !cmd_valid_o);
endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;
  localparam int NUM_REGS  = 4;
  localparam int SETTLE_MS = 80;
  localparam int RETRY_MS  = 10;
  localparam int MAX_TRIES = 16;
  localparam int TICK_DIV  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, shutdown_i = 1'b0, ms_tick_i = 1'b0;
  logic [8*NUM_REGS-1:0] tbl_sub_i, tbl_dat_i;
  logic cmd_valid_o, cmd_ready_i = 1'b0;
  logic [7:0] cmd_addr_o, cmd_sub_o, cmd_data_o;
  logic rsp_valid_i = 1'b0, rsp_nack_i = 1'b0;
  logic busy_o, done_o, error_o;

  int checks = 0, fails = 0;
  int tick_count = 0;
  int tick_v, tick_r;

  assign tbl_sub_i = {8'h05, 8'h11, 8'h03, 8'h07};
  assign tbl_dat_i = {8'h0F, 8'h81, 8'h3C, 8'hA5};

  always #4 clk = ~clk;

  pwrup_seq #(.NUM_REGS(NUM_REGS), .SETTLE_MS(SETTLE_MS), .RETRY_MS(RETRY_MS),
              .MAX_TRIES(MAX_TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
    .ms_tick_i(ms_tick_i), .tbl_sub_i(tbl_sub_i), .tbl_dat_i(tbl_dat_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_addr_o(cmd_addr_o),
    .cmd_sub_o(cmd_sub_o), .cmd_data_o(cmd_data_o), .rsp_valid_i(rsp_valid_i),
    .rsp_nack_i(rsp_nack_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o));

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 ms_tick_i = 1'b1;
      @(posedge clk);
      #1 ms_tick_i = 1'b0;
    end
  end

  always @(posedge clk) if (ms_tick_i) tick_count <= tick_count + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic status(input string req, input bit b, input bit d, input bit e);
    chk(busy_o == b, req, "busy", busy_o, b);
    chk(done_o == d, req, "done", done_o, d);
    chk(error_o == e, req, "error", error_o, e);
  endtask

  task automatic quiet(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cmd_valid_o) seen = 1;
    end
    chk(!seen, req, "no command offered", seen, 0);
  endtask

  task automatic pulse(input bit which_shut);
    @(negedge clk);
    if (which_shut) shutdown_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    shutdown_i = 1'b0; start_i = 1'b0;
  endtask

  // Model of the bus master: wait for a command, accept it after a delay, respond.
  task automatic serve(input logic [7:0] es, input logic [7:0] ed, input bit nack,
                       input int rdy_delay, input string req,
                       output int tv, output int tr);
    int w = 0;
    logic [7:0] s0, d0;
    while (!cmd_valid_o && w < 3000) begin @(negedge clk); w++; end
    tv = tick_count;
    chk(cmd_valid_o, req, "command offered", cmd_valid_o, 1);
    chk(cmd_addr_o == 8'h8C, req, "address", cmd_addr_o, 8'h8C);
    chk(cmd_sub_o == es, req, "subaddress", cmd_sub_o, es);
    chk(cmd_data_o == ed, req, "data", cmd_data_o, ed);
    s0 = cmd_sub_o; d0 = cmd_data_o;
    for (int i = 0; i < rdy_delay; i++) begin
      @(negedge clk);
      chk(cmd_valid_o && cmd_sub_o == s0 && cmd_data_o == d0, "R3", "held under back-pressure",
          {cmd_valid_o, cmd_sub_o, cmd_data_o}, {1'b1, s0, d0});
    end
    cmd_ready_i = 1'b1;
    @(negedge clk);
    cmd_ready_i = 1'b0;
    chk(!cmd_valid_o, "R3", "valid drops after handshake", cmd_valid_o, 0);
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o, "R3", "nothing new before response", cmd_valid_o, 0);
    rsp_valid_i = 1'b1; rsp_nack_i = nack;
    tr = tick_count;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_nack_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    status("R1", 0, 0, 0);
    chk(!cmd_valid_o, "R1", "valid after reset", cmd_valid_o, 0);
  endtask

  task automatic t_nominal();
    int t_last;
    pulse(0);
    status("R2", 1, 0, 0);
    serve(8'h1A, 8'h00, 0, 3, "R2", tick_v, tick_r);
    for (int i = 0; i < NUM_REGS; i++) begin
      serve(tbl_sub_i[8*i +: 8], tbl_dat_i[8*i +: 8], 0, i % 2, "R6", tick_v, tick_r);
      if (i == 1) pulse(0); // R11: start while busy must not disturb the table order
    end
    t_last = tick_r;
    chk(busy_o, "R8", "busy during settle", busy_o, 1);
    serve(8'h1A, 8'h02, 0, 0, "R9", tick_v, tick_r);
    chk((tick_v - t_last) >= SETTLE_MS && (tick_v - t_last) <= SETTLE_MS + 1,
        "R8", "ticks before soft-start", tick_v - t_last, SETTLE_MS);
    status("R9", 0, 1, 0);
  endtask

  task automatic t_shutdown();
    pulse(0);
    quiet(10, "R11");
    status("R11", 0, 1, 0);
    pulse(1);
    serve(8'h1A, 8'h00, 0, 1, "R10", tick_v, tick_r);
    status("R10", 0, 0, 0);
  endtask

  task automatic t_retry_then_table_nack();
    int prev_r;
    pulse(0);
    serve(8'h1A, 8'h00, 1, 0, "R4", tick_v, prev_r);
    for (int k = 0; k < 3; k++) begin
      serve(8'h1A, 8'h00, (k < 2), 0, "R4", tick_v, tick_r);
      chk((tick_v - prev_r) >= RETRY_MS && (tick_v - prev_r) <= RETRY_MS + 1,
          "R4", "ticks before retry", tick_v - prev_r, RETRY_MS);
      prev_r = tick_r;
    end
    serve(tbl_sub_i[7:0], tbl_dat_i[7:0], 0, 0, "R6", tick_v, tick_r);
    serve(tbl_sub_i[15:8], tbl_dat_i[15:8], 1, 0, "R7", tick_v, tick_r);
    status("R7", 0, 0, 1);
    quiet(120, "R7");
  endtask

  task automatic t_exhaust();
    pulse(0);
    status("R11", 1, 0, 0);
    for (int k = 0; k < MAX_TRIES; k++) begin
      serve(8'h1A, 8'h00, 1, 0, "R5", tick_v, tick_r);
      if (k < MAX_TRIES - 1) status("R5", 1, 0, 0);
    end
    status("R5", 0, 0, 1);
    quiet(20 * TICK_DIV, "R5");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_shutdown();
    t_retry_then_table_nack();
    t_exhaust();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule